// File: doc/BRIEF.md
# Reloading Down-Timer with Continuous Square-Wave Output

This block is a down counter with a reload register that drives a square wave. While it runs, every count-clock enable pulse lowers the counter by one. A tick that finds the counter at zero is an underflow. On that tick the counter wraps to all ones, the output flip-flop changes level, and an interrupt pulse one system clock long is raised. The tick that follows loads the reload value minus one, and counting goes on. Each output level therefore lasts reload+1 ticks, and the output is a continuous square wave.

Software starts the timer by setting the enable bit through the register write port. An external enable input can also start it. A software write that clears the enable bit takes priority over an external enable in the same clock. While the timer is stopped, the counter and the output keep their values, and a write to the counter sets the count from which the timer will start. The current count can be read through the register read port at any time.

The controller has four states. ST_STOP: disabled. ST_RUN: counting down. ST_WRAP: the counter sits at all ones after an underflow and waits for the reload tick. ST_HOLDWRAP: the timer was disabled during ST_WRAP, and the reload is still pending. The transitions are:
- STOP→RUN on enable.
- RUN→STOP on disable.
- RUN→WRAP on a tick at zero.
- WRAP→RUN on the reload tick when the reload value is nonzero.
- WRAP→WRAP on each tick when the reload value is zero.
- WRAP→HOLDWRAP on disable.
- HOLDWRAP→WRAP on enable.
- HOLDWRAP→STOP or RUN when software writes the counter.

Top module: `tmr_reload_top`

## Requirements
- R1: After reset the enable bit, the output, the interrupt, the counter and the reload value are all zero. The register addresses are: 0 = control (write bit 0 = enable; read bit 0 = enable, read bit 1 = output level), 1 = reload, 2 = counter. Address 3 reads as zero.
- R2: The timer starts when software writes control bit 0 as 1, or when ext_en is high for one clock. The enable stays set until software clears it.
- R3: When software writes control bit 0 as 0 in the same clock that ext_en is high, the enable ends up clear and no counting takes place.
- R4: While the timer runs, each cnt_tick lowers the counter by one. A tick in the clock where the enable is given has no effect, so the first count falls on the next tick.
- R5: A tick that finds the counter at zero makes the counter read 0xFFFFFF, inverts tmr_out, and raises uf_irq for exactly one clock. Apart from this, uf_irq stays low and tmr_out does not change.
- R6: The tick after an underflow loads reload−1 into the counter, so each output level lasts reload+1 ticks.
- R7: With a reload value of zero, every tick is an underflow and the counter stays at 0xFFFFFF.
- R8: While the timer is disabled, ticks have no effect, and the counter and the output hold their values.
- R9: A counter write while the timer is disabled sets the count. A counter write while it runs is ignored.
- R10: If the timer is disabled in the all-ones cycle and enabled again later, its next tick loads reload−1.
- R11: A reload write does not change the count in progress. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-clock enable, one system clock per count |
| ext_en | input | 1 | External start request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 24 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 24 | Register read data (combinational) |
| tmr_out | output | 1 | Output flip-flop level |
| uf_irq | output | 1 | Underflow interrupt pulse |

## Verification
Register writes, the enable and ticks take effect at the edge where they are sampled. The counter, tmr_out and uf_irq therefore show the result one clock after the stimulus, and the bench samples them just after that edge. Reads are combinational, so they are taken in the same settled window. The bench sweeps reload values 0 to 5, with a tick on every clock and with a tick on every third clock. For each tick it computes the expected count, the number of underflows and the interrupt level arithmetically from the tick index, and it checks in the idle clocks between ticks that nothing moves.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd2;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_RUN      = 2'd1,
        ST_WRAP     = 2'd2,
        ST_HOLDWRAP = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              run_d,
    output logic              run_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              cnt_wr
);
    logic ctrl_wr;
    logic reload_wr;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign reload_wr = wr_en && (wr_addr == ADDR_RELOAD);
    assign cnt_wr    = wr_en && (wr_addr == ADDR_COUNT);

    // A software write to the enable bit overrides the external start.
    always_comb begin
        if (ctrl_wr) begin
            run_d = wr_data[0];
        end else if (ext_en) begin
            run_d = 1'b1;
        end else begin
            run_d = run_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            reload_q <= '0;
        end else begin
            run_q <= run_d;
            if (reload_wr) begin
                reload_q <= wr_data;
            end
        end
    end

    // R3: disable and external enable in the same clock leave the timer off
    a_r3_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[0] && ext_en) |=> !run_q);

    // R2: an external enable without a control write starts the timer
    a_r2_ext_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !ctrl_wr) |=> run_q);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_d,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             out_q,
    output logic             irq_q
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ZERO     = '0;

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_d;
    logic             uf;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        uf    = 1'b0;
        unique case (st_q)
            ST_STOP: begin
                if (cnt_wr) begin
                    cnt_d = cnt_wdata;
                end
                if (run_d) begin
                    st_d = ST_RUN;
                end
            end
            ST_HOLDWRAP: begin
                if (cnt_wr) begin
                    cnt_d = cnt_wdata;
                    st_d  = run_d ? ST_RUN : ST_STOP;
                end else if (run_d) begin
                    st_d = ST_WRAP;
                end
            end
            ST_RUN: begin
                if (!run_d) begin
                    st_d = ST_STOP;
                end else if (tick) begin
                    if (cnt_q == ZERO) begin
                        cnt_d = ALL_ONES;
                        st_d  = ST_WRAP;
                        uf    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_WRAP: begin
                if (!run_d) begin
                    st_d = ST_HOLDWRAP;
                end else if (tick) begin
                    if (reload_q == ZERO) begin
                        uf = 1'b1;
                    end else begin
                        cnt_d = reload_q - 1'b1;
                        st_d  = ST_RUN;
                    end
                end
            end
        endcase
    end

    // state and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            out_q <= out_q ^ uf;
            irq_q <= uf;
        end
    end

    // R5: the counter shows all ones right after a tick at zero
    a_r5_wrap_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && run_d && tick && cnt_q == ZERO) |=> (cnt_q == ALL_ONES));

    // R5: interrupt and output inversion go together
    a_r5_irq_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (out_q != $past(out_q)));
    a_r5_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> $stable(out_q));

    // R6: the reload tick loads reload minus one
    a_r6_reload_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRAP && run_d && tick && reload_q != ZERO)
        |=> (cnt_q == $past(reload_q) - 1'b1));

    // R8: stopped without a counter write holds everything
    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && !cnt_wr) |=> ($stable(cnt_q) && $stable(out_q)));
endmodule

// File: rtl/tmr_reload_top.sv
module tmr_reload_top
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              ext_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              tmr_out,
    output logic              uf_irq
);
    logic             run_d;
    logic             run_q;
    logic             cnt_wr;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_en   (ext_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .run_d    (run_d),
        .run_q    (run_q),
        .reload_q (reload_q),
        .cnt_wr   (cnt_wr)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .run_d     (run_d),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .reload_q  (reload_q),
        .cnt_q     (cnt_q),
        .out_q     (tmr_out),
        .irq_q     (uf_irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[0] = run_q;
                rd_data[1] = tmr_out;
            end
            ADDR_RELOAD: rd_data = reload_q;
            ADDR_COUNT:  rd_data = cnt_q;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: tb/tmr_reload_top_tb.sv
module tmr_reload_top_tb;
    localparam int CLK_P = 10;
    localparam int W = 24;
    localparam logic [W-1:0] ONES = '1;
    localparam logic [1:0] A_CTRL = 2'd0, A_REL = 2'd1, A_CNT = 2'd2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0, ext_en = 1'b0, wr_en = 1'b0;
    logic [1:0]   wr_addr = '0, rd_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         tmr_out, uf_irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    tmr_reload_top #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_en(ext_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_out(tmr_out), .uf_irq(uf_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic e, input logic w,
                       input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        cnt_tick = t; ext_en = e; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic out0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and address map
        rd(A_CTRL, v); chk("R1 ctrl", v, '0);
        rd(A_REL, v);  chk("R1 reload", v, '0);
        rd(A_CNT, v);  chk("R1 count", v, '0);
        rd(2'd3, v);   chk("R1 addr3", v, '0);
        chk("R1 irq", {23'd0, uf_irq}, '0);

        // R4-R7 sweep: reload 0..5, tick every clock and every third clock
        for (int p = 1; p <= 3; p += 2) begin
            for (int r = 0; r <= 5; r++) begin
                cyc(0, 0, 1, A_CTRL, '0);
                cyc(0, 0, 1, A_REL, W'(r));
                cyc(0, 0, 1, A_CNT, W'(2));
                out0 = tmr_out;
                cyc(1, 0, 1, A_CTRL, W'(1));
                rd(A_CNT, v); chk("R4 tick on enable ignored", v, W'(2));
                for (int k = 1; k <= 14; k++) begin
                    int j, m, nuf;
                    logic [W-1:0] ec;
                    logic eirq;
                    cyc(1, 0, 0, 2'd0, '0);
                    if (k <= 2) begin
                        ec = W'(2 - k); nuf = 0; eirq = 1'b0;
                    end else begin
                        j = k - 3; m = j % (r + 1); nuf = 1 + j / (r + 1);
                        ec = (m == 0) ? ONES : W'(r - m);
                        eirq = (m == 0);
                    end
                    rd(A_CNT, v);
                    chk(r == 0 ? "R7 count" : "R4/R6 count", v, ec);
                    chk("R5 out", {23'd0, tmr_out}, {23'd0, out0 ^ nuf[0]});
                    chk("R5 irq", {23'd0, uf_irq}, {23'd0, eirq});
                    for (int q = 1; q < p; q++) begin
                        cyc(0, 0, 0, 2'd0, '0);
                        chk("R5 irq one clock", {23'd0, uf_irq}, '0);
                        rd(A_CNT, v); chk("R4 no tick no count", v, ec);
                    end
                end
            end
        end

        // R2 external start, enable sticks
        cyc(0, 0, 1, A_CTRL, '0);
        cyc(0, 0, 1, A_CNT, W'(5));
        cyc(0, 1, 0, 2'd0, '0);
        rd(A_CTRL, v); chk("R2 ext start", {23'd0, v[0]}, W'(1));
        idle(2);
        rd(A_CTRL, v); chk("R2 enable sticks", {23'd0, v[0]}, W'(1));
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R2 counts", v, W'(4));

        // R9 counter write ignored while running
        cyc(0, 0, 1, A_CNT, W'(9));
        rd(A_CNT, v); chk("R9 write ignored running", v, W'(4));

        // R3 disable wins
        cyc(0, 1, 1, A_CTRL, '0);
        rd(A_CTRL, v); chk("R3 disable wins", {23'd0, v[0]}, '0);
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R3 no count", v, W'(4));

        // R8 ticks ignored while disabled
        out0 = tmr_out;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R8 count held", v, W'(4));
        chk("R8 out held", {23'd0, tmr_out}, {23'd0, out0});

        // R9 counter write while stopped
        cyc(0, 0, 1, A_CNT, W'(9));
        rd(A_CNT, v); chk("R9 write stopped", v, W'(9));

        // R10 disable in all-ones cycle, re-enable
        cyc(0, 0, 1, A_REL, W'(4));
        cyc(0, 0, 1, A_CNT, W'(0));
        cyc(0, 0, 1, A_CTRL, W'(1));
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R10 wrapped", v, ONES);
        cyc(0, 0, 1, A_CTRL, '0);
        out0 = tmr_out;
        cyc(1, 0, 0, 2'd0, '0);
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R10 held ones", v, ONES);
        chk("R10 out held", {23'd0, tmr_out}, {23'd0, out0});
        cyc(0, 0, 1, A_CTRL, W'(1));
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R10 reload after resume", v, W'(3));

        // R11 reload change used only at next reload
        cyc(0, 0, 1, A_REL, W'(7));
        rd(A_CNT, v); chk("R11 count kept", v, W'(3));
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R11 counted down", v, W'(0));
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R11 underflow", v, ONES);
        cyc(1, 0, 0, 2'd0, '0);
        rd(A_CNT, v); chk("R11 new reload", v, W'(6));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule